// File: doc/BRIEF.md
# Interval Timer with Buffered Compare

This block is a 16-bit up-counting interval timer controlled through a small register interface. Software writes an interval value into a data register. It selects one of four count rates and sets a run bit. From then on, the counter advances once per selected tick until it equals a compare latch. At that point the block sets a match flag, inverts an output pin and starts counting again from zero. With interval value n and tick period P, one interval lasts P × (n+1). The pin therefore runs at 1/(2 × P × (n+1)).

The compare latch is buffered behind the data register. While the timer is stopped, a data write goes straight into the latch. While it runs, a data write only changes the data register. The new value reaches the latch at the next match, and only if software has posted a load request. The live count can be read as two bytes at any time. The match flag is also brought out as a port for use as an interrupt request.

Top module: `ivl_timer`

## Requirements
- R1: After reset, the control register reads 0, the count reads 0, the data register reads 0xFFFF, and matchFlag and timerOut are 0.
- R2: Control register (address 0) bits [2:1] select the tick rate as one tick every 2^sel clock cycles (1, 2, 4 or 8). With interval value n, timerOut toggles every 2^sel × (n+1) cycles.
- R3: Writing control bit 0 (run) as 1 while stopped clears the count to 0 at that edge. The count then rises by one per tick.
- R4: On a tick where the count equals the compare latch, matchFlag becomes 1 and the count returns to 0. The count therefore runs through 0..n, and with the divide-by-1 rate the first match appears n+1 cycles after the start edge.
- R5: timerOut inverts on every match and on nothing else.
- R6: A write to the data register (address 1) while stopped loads the compare latch at the same edge. The data register reads back on address 1.
- R7: While running, a data write leaves the interval unchanged unless a load request is pending. Software posts a load request by writing 1 to control bit 4. At the next match the latch takes the data register value, and bit 4 reads back 0.
- R8: Writing control bit 3 as 0 clears matchFlag. Writing it as 1 leaves the flag unchanged.
- R9: If a write clearing the flag lands on the same edge as a match, matchFlag remains 1.
- R10: Writing run as 0 freezes the count at its current value. No further matches occur and timerOut holds its level.
- R11: Address 2 reads the count's low byte and address 3 reads its high byte, both on rdData[7:0] with the upper bits 0. Address 0 reads run in bit 0, the rate in bits [2:1], the flag in bit 3 and the load request in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 data |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address: 0 control, 1 data, 2 count low, 3 count high |
| rdData | output | 16 | Combinational read data |
| matchFlag | output | 1 | Sticky match flag |
| timerOut | output | 1 | Toggle output |

## Verification
Every register write takes effect at the clock edge that samples it, so the bench drives inputs at the falling edge and reads results at the next falling edge. The read path is combinational and can be sampled straight after rdAddr changes. With the divide-by-1 rate, counting from a start edge E0 gives a count of k after edge Ek, and the first match shows on matchFlag and timerOut after edge E(n+1). For the other rates the prescaler phase is free-running, so the bench measures the spacing between two pin toggles instead of the absolute edge. It places the flag-clear write exactly on edge E(n+1) to hit the clear-versus-match collision.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int RATE_W = 2;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLO  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CHI  = 2'd3;

  localparam int BIT_RUN  = 0;
  localparam int BIT_RATE = 1;
  localparam int BIT_FLAG = BIT_RATE + RATE_W;
  localparam int BIT_LREQ = BIT_FLAG + 1;

  localparam logic [CNT_W-1:0] DATA_RST = '1;

  typedef struct packed {
    logic clrCount;
    logic incCount;
    logic toggleOut;
    logic latchFromData;
    logic latchFromBus;
  } dpCtl_t;
endpackage

// File: rtl/ivl_prescaler.sv
module ivl_prescaler #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateSel,
  output logic              tick
);
  localparam int PRE_W = (1 << RATE_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < int'(rateSel));
    end
  end

  assign tick = ((preCnt & mask) == mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end
endmodule

// File: rtl/ivl_ctrl.sv
module ivl_ctrl
  import ivl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              countEq,
  output dpCtl_t            dpCtl,
  output logic              dataWr,
  output logic              run,
  output logic [RATE_W-1:0] rateSel,
  output logic              matchFlag,
  output logic              loadReq
);
  logic ctrlWr, startPulse, stopWr, countEn, matchNow, tick;

  ivl_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .tick(tick)
  );

  always_comb begin
    ctrlWr     = wrEn && (wrAddr == ADDR_CTRL);
    dataWr     = wrEn && (wrAddr == ADDR_DATA);
    startPulse = ctrlWr && wrData[BIT_RUN] && !run;
    stopWr     = ctrlWr && !wrData[BIT_RUN];
    countEn    = run && tick && !stopWr;
    matchNow   = countEn && countEq;

    dpCtl.clrCount      = startPulse || matchNow;
    dpCtl.incCount      = countEn && !countEq;
    dpCtl.toggleOut     = matchNow;
    dpCtl.latchFromData = matchNow && loadReq;
    dpCtl.latchFromBus  = dataWr && !run;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run       <= 1'b0;
      rateSel   <= '0;
      matchFlag <= 1'b0;
      loadReq   <= 1'b0;
    end else begin
      if (ctrlWr) begin
        run     <= wrData[BIT_RUN];
        rateSel <= wrData[BIT_RATE +: RATE_W];
      end
      if (matchNow)
        matchFlag <= 1'b1;
      else if (ctrlWr && !wrData[BIT_FLAG])
        matchFlag <= 1'b0;
      if (ctrlWr && wrData[BIT_LREQ])
        loadReq <= 1'b1;
      else if (matchNow && loadReq)
        loadReq <= 1'b0;
    end
  end
endmodule

// File: rtl/ivl_datapath.sv
module ivl_datapath
  import ivl_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           dpCtl,
  input  logic             dataWr,
  input  logic [CNT_W-1:0] busData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] latchVal,
  output logic [CNT_W-1:0] dataReg,
  output logic             countEq,
  output logic             timerOut
);
  assign countEq = (count == latchVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      latchVal <= DATA_RST;
      dataReg  <= DATA_RST;
      timerOut <= 1'b0;
    end else begin
      if (dpCtl.clrCount)      count <= '0;
      else if (dpCtl.incCount) count <= count + 1'b1;

      if (dpCtl.latchFromBus)       latchVal <= busData;
      else if (dpCtl.latchFromData) latchVal <= dataReg;

      if (dataWr) dataReg <= busData;
      if (dpCtl.toggleOut) timerOut <= !timerOut;
    end
  end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              matchFlag,
  output logic              timerOut
);
  localparam int BYTE_W = 8;

  dpCtl_t            dpCtl;
  logic              dataWr, run, loadReq, countEq;
  logic [RATE_W-1:0] rateSel;
  logic [CNT_W-1:0]  count, latchVal, dataReg;

  ivl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .countEq(countEq), .dpCtl(dpCtl), .dataWr(dataWr), .run(run),
    .rateSel(rateSel), .matchFlag(matchFlag), .loadReq(loadReq)
  );

  ivl_datapath u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .dataWr(dataWr), .busData(wrData),
    .count(count), .latchVal(latchVal), .dataReg(dataReg),
    .countEq(countEq), .timerOut(timerOut)
  );

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL: begin
        rdData[BIT_RUN]               = run;
        rdData[BIT_RATE +: RATE_W]    = rateSel;
        rdData[BIT_FLAG]              = matchFlag;
        rdData[BIT_LREQ]              = loadReq;
      end
      ADDR_DATA: rdData = dataReg;
      ADDR_CLO:  rdData[BYTE_W-1:0] = count[BYTE_W-1:0];
      default:   rdData[BYTE_W-1:0] = count[2*BYTE_W-1:BYTE_W];
    endcase
  end
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk
  import ivl_timer_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             loadReq,
  input logic             matchFlag,
  input logic             timerOut,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] latchVal
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (count <= latchVal)); // R4

  AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (timerOut != $past(timerOut)) |-> (matchFlag && count == '0)); // R5

  AST_FLAG_WITH_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> (timerOut != $past(timerOut))); // R4

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !$past(run)) |-> ($stable(count) && $stable(timerOut))); // R10

  AST_LREQ_AT_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loadReq) |-> (count == '0 && timerOut != $past(timerOut))); // R7
endmodule

bind ivl_timer ivl_timer_chk chk (
  .clk(clk), .rstN(rstN), .run(run), .loadReq(loadReq),
  .matchFlag(matchFlag), .timerOut(timerOut), .count(count), .latchVal(latchVal)
);

// File: tb/tb_ivl_timer.sv
module tb_ivl_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        matchFlag, timerOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ivl_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .matchFlag(matchFlag), .timerOut(timerOut)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0] n;
    logic [1:0]  sel;
    logic [15:0] period;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{n:16'd5, sel:2'd0, period:16'd6},
    '{n:16'd0, sel:2'd0, period:16'd1},
    '{n:16'd9, sel:2'd1, period:16'd20},
    '{n:16'd3, sel:2'd2, period:16'd16},
    '{n:16'd4, sel:2'd3, period:16'd40},
    '{n:16'd0, sel:2'd3, period:16'd8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rdAddr = a;
    #1 v = int'(rdData);
  endtask

  task automatic measure(output int p);
    logic prev;
    int   c;
    p = -1;
    @(negedge clk);
    prev = timerOut;
    c = 0;
    while (timerOut == prev && c < 2000) begin @(negedge clk); c++; end
    if (c < 2000) begin
      prev = timerOut;
      c = 0;
      while (timerOut == prev && c < 2000) begin @(negedge clk); c++; end
      if (c < 2000) p = c;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, v2, p;
    logic o;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 count", v, 0);
    rd(2'd1, v); chk("R1 data", v, 16'hFFFF);
    chk("R1 flag", matchFlag, 0);
    chk("R1 out", timerOut, 0);

    // R2 rate and interval table
    foreach (VECS[i]) begin
      wr(2'd0, {13'd0, VECS[i].sel, 1'b0});
      wr(2'd1, VECS[i].n);
      wr(2'd0, {13'd0, VECS[i].sel, 1'b1});
      measure(p);
      chk($sformatf("R2 period vec%0d", i), p, int'(VECS[i].period));
    end

    // R11 count bytes, R10 freeze, R3 restart clear
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h1FFF);
    wr(2'd0, 16'h0001);
    repeat (300) @(posedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R11 count low", v, 16'h2C);
    rd(2'd3, v); chk("R11 count high", v, 16'h01);
    rd(2'd0, v); chk("R11 ctrl readback", v, 16'h0001);
    wr(2'd0, 16'h0000);
    @(negedge clk);
    rd(2'd2, v);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rd(2'd2, v2); chk("R10 count frozen", v2, v);
    wr(2'd0, 16'h0001);
    @(negedge clk);
    rd(2'd2, v); chk("R3 start clears", v, 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(2'd2, v); chk("R3 counts up", v, 5);

    // R6 stopped load, R4 first match, R5 toggle
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd3);
    rd(2'd1, v); chk("R6 data readback", v, 3);
    o = timerOut;
    wr(2'd0, 16'h0001);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 no early match", matchFlag, 0);
    rd(2'd2, v); chk("R4 count at n", v, 3);
    @(posedge clk);
    @(negedge clk);
    chk("R4 match flag", matchFlag, 1);
    rd(2'd2, v); chk("R4 count wraps", v, 0);
    chk("R5 toggled", timerOut, int'(!o));

    // R9 clear collides with match
    wr(2'd0, 16'h0000);
    chk("R8 clear flag", matchFlag, 0);
    wr(2'd0, 16'h0001);
    repeat (3) @(posedge clk);
    wr(2'd0, 16'h0001);
    @(negedge clk);
    chk("R9 match wins", matchFlag, 1);

    // R8 write 1 keeps flag, write 0 clears
    wr(2'd0, 16'h0008);
    @(negedge clk);
    chk("R8 write one keeps", matchFlag, 1);
    wr(2'd0, 16'h0000);
    @(negedge clk);
    chk("R8 write zero clears", matchFlag, 0);

    // R10 stopped: no matches, pin holds
    o = timerOut;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R10 no match", matchFlag, 0);
    chk("R10 pin holds", timerOut, int'(o));

    // R7 buffered reload
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0009);
    wr(2'd1, 16'd7);
    measure(p); chk("R7 no request keeps interval", p, 4);
    wr(2'd0, 16'h0019);
    rd(2'd0, v); chk("R7 request pending", (v >> 4) & 1, 1);
    measure(p); chk("R7 new interval", p, 8);
    rd(2'd0, v); chk("R7 request cleared", (v >> 4) & 1, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule